// File: doc/BRIEF.md
# Latched-Request Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output for a processor core. A parameter gives each line a trigger kind. A rising edge on an edge line sets that line's pending bit. A high level on a level line also sets the bit. In both cases the bit stays set after the source drops, until software acknowledges it. A per-line enable mask, together with a global interrupt enable, decides whether pending bits reach the `irq_o` output. A second control bit, the tick enable, is passed straight out to a timer.

Software reaches the mask, the pending word and the control word through a plain synchronous register port. An acknowledge is a write to the pending word. The parameter `CLR_ON_ZERO` selects how that write is read: either a written 1 clears the bit, or a written 0 clears it and a 1 leaves it alone. The block also gives the index of the lowest-numbered line that is both pending and enabled, with a flag that says whether any such line exists. A service loop can use these to handle lines in ascending order.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the mask, the pending word and the control word all read 0, `irq_o` is 0 and `low_vld_o` is 0.
- R2: A write to address 0 loads the mask from `reg_wdata_i[NUM_LINES-1:0]`. A read of address 0 returns that value, zero-extended. No other access changes the mask.
- R3: On an edge line (`EDGE_SEL` bit = 1), a 0-to-1 transition of the request sets the pending bit at the next clock edge. The bit stays set after the request falls. A request held high does not set the bit again once it has been cleared.
- R4: On a level line (`EDGE_SEL` bit = 0), any cycle with the request high sets the pending bit. The bit stays set after the request falls. Clearing the bit while the request is still high leaves it set.
- R5: With `CLR_ON_ZERO`=0, a write to address 1 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 are not changed.
- R6: With `CLR_ON_ZERO`=1, a write to address 1 clears each pending bit whose write-data bit is 0. Pending bits whose write-data bit is 1 are not changed.
- R7: When a line's set condition and a clear of that line occur in the same cycle, the bit ends up set.
- R8: `irq_o` is 1 exactly when control bit 0 (interrupt enable) is 1 and at least one bit of pending AND mask is 1. Masked lines still latch their pending bits.
- R9: `low_vld_o` is 1 exactly when pending AND mask is nonzero. `low_idx_o` then gives the lowest set bit position of that AND.
- R10: A write to address 2 loads control bit 0 (interrupt enable) and bit 1 (tick enable). A read of address 2 returns those two bits and zeros above them. `tick_en_o` follows bit 1.
- R11: When `reg_rd_i` is high, `reg_rdata_o` shows the addressed register after the next clock edge. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_LINES | Request lines, already synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 pending, 2 control |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| tick_en_o | output | 1 | Timer tick enable from control bit 1 |
| low_idx_o | output | IDX_W | Lowest pending enabled line |
| low_vld_o | output | 1 | Some pending enabled line exists |

## Verification
The bench sweeps every pending pattern of an eight-line build against a wide spread of masks and compares the lowest-index output with an arithmetic search. An encoder that scanned from the top, or that ignored the mask, would report the wrong line on almost every pattern. Directed cases then target the acknowledge polarity, using one instance of each polarity: an inverted clear would wipe out unrelated lines or leave the acknowledged one pending. A clear that lands in the same cycle as a new edge must leave the bit set, because losing that race drops an interrupt. A level line cleared while it is still high must come back at once. An edge line held high must not re-arm, or it would fire over and over.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_MASK   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int CTRL_IE_BIT   = 0;
  localparam int CTRL_TICK_BIT = 1;
endpackage

// File: rtl/irq_trig_detect.sv
module irq_trig_detect #(
  parameter int N = 32,
  parameter logic [N-1:0] EDGE_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] set_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_line
    if (EDGE_SEL[gi]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req_i[gi];
      end
      assign set_o[gi] = req_i[gi] & ~prev_q;
    end else begin : g_level
      assign set_o[gi] = req_i[gi];
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 32,
  parameter bit CLR_ON_ZERO = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         ack_we_i,
  input  logic [N-1:0] ack_data_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] clr;
  logic [N-1:0] pend_q;

  if (CLR_ON_ZERO) begin : g_zero_clr
    assign clr = ack_we_i ? ~ack_data_i : '0;
  end else begin : g_one_clr
    assign clr = ack_we_i ? ack_data_i : '0;
  end

  // a set in the same cycle overrides the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W = 32,
  parameter logic [NUM_LINES-1:0] EDGE_SEL = NUM_LINES'(32'h0000_FFFF),
  parameter bit CLR_ON_ZERO = 1'b0,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_req_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o,
  output logic                  tick_en_o,
  output logic [IDX_W-1:0]      low_idx_o,
  output logic                  low_vld_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr_i);

  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] mask_q;
  logic                 ie_q;
  logic                 tick_q;
  logic [DATA_W-1:0]    rdata_q;
  logic [DATA_W-1:0]    rd_mux;
  logic                 ack_we;
  logic [NUM_LINES-1:0] active;

  irq_trig_detect #(.N(NUM_LINES), .EDGE_SEL(EDGE_SEL)) u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (irq_req_i),
    .set_o (set_vec)
  );

  assign ack_we = reg_wr_i && (sel == SEL_STATUS);

  irq_pend_bank #(.N(NUM_LINES), .CLR_ON_ZERO(CLR_ON_ZERO)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .ack_we_i   (ack_we),
    .ack_data_i (reg_wdata_i[NUM_LINES-1:0]),
    .pend_o     (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ie_q   <= 1'b0;
      tick_q <= 1'b0;
    end else if (reg_wr_i) begin
      if (sel == SEL_MASK) mask_q <= reg_wdata_i[NUM_LINES-1:0];
      if (sel == SEL_CTRL) begin
        ie_q   <= reg_wdata_i[CTRL_IE_BIT];
        tick_q <= reg_wdata_i[CTRL_TICK_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MASK:   rd_mux[NUM_LINES-1:0] = mask_q;
      SEL_STATUS: rd_mux[NUM_LINES-1:0] = pend;
      SEL_CTRL: begin
        rd_mux[CTRL_IE_BIT]   = ie_q;
        rd_mux[CTRL_TICK_BIT] = tick_q;
      end
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign active = pend & mask_q;

  irq_lowest_enc #(.N(NUM_LINES)) u_enc (
    .vec_i (active),
    .idx_o (low_idx_o),
    .vld_o (low_vld_o)
  );

  assign irq_o       = ie_q & (|active);
  assign tick_en_o   = tick_q;
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N = 32,
  parameter logic [N-1:0] EDGE_SEL = '0,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [N-1:0]     req,
  input logic [N-1:0]     mask,
  input logic [N-1:0]     pend,
  input logic             ie,
  input logic             irq,
  input logic [IDX_W-1:0] idx,
  input logic             vld
);
  a_r3_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd1) |=> ((pend & $past(pend)) == $past(pend)));

  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req & ~EDGE_SEL)) |=> ((pend & $past(req & ~EDGE_SEL)) == $past(req & ~EDGE_SEL)));

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd0) |=> $stable(mask));

  a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && vld));

  a_r8_irq_when_live: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && vld) |-> irq);

  a_r9_idx_hits: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (pend[idx] && mask[idx]));

  a_r9_none_below: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((pend & mask & ((N'(1) << idx) - N'(1))) == '0));

  a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> ((pend & mask) == '0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N(NUM_LINES), .EDGE_SEL(EDGE_SEL)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr    (reg_wr_i),
  .addr  (reg_addr_i),
  .req   (irq_req_i),
  .mask  (mask_q),
  .pend  (pend),
  .ie    (ie_q),
  .irq   (irq_o),
  .idx   (low_idx_o),
  .vld   (low_vld_o)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int N = 8;
  localparam int DW = 32;
  localparam logic [N-1:0] ESEL = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic wr_a = 1'b0, wr_b = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_a, rdata_b;
  logic irq_a, irq_b, tick_a, tick_b, vld_a, vld_b;
  logic [2:0] idx_a, idx_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl #(.NUM_LINES(N), .DATA_W(DW), .EDGE_SEL(ESEL), .CLR_ON_ZERO(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .reg_wr_i(wr_a), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_a), .irq_o(irq_a),
    .tick_en_o(tick_a), .low_idx_o(idx_a), .low_vld_o(vld_a));

  irq_ctrl #(.NUM_LINES(N), .DATA_W(DW), .EDGE_SEL(ESEL), .CLR_ON_ZERO(1'b1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .reg_wr_i(wr_b), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_b), .irq_o(irq_b),
    .tick_en_o(tick_b), .low_idx_o(idx_b), .low_vld_o(vld_b));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit to_a, input bit to_b, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_a = to_a; wr_b = to_b; addr = a; wdata = d;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    @(negedge clk); req = p;
    @(negedge clk); req = '0;
    @(negedge clk);
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(irq_a == 1'b0, "R1 irq", irq_a, 0);
    check(vld_a == 1'b0, "R1 vld", vld_a, 0);
    for (int a = 0; a < 3; a++) begin
      rd_reg(a[1:0]);
      check(rdata_a == 0, "R1 reg", rdata_a, 0);
    end
    // R11 unmapped
    rd_reg(2'd3);
    check(rdata_a == 0, "R11 unmapped", rdata_a, 0);
    // R2 mask write and readback
    wr_reg(1, 0, 2'd0, 32'hFFFF_FFA5);
    rd_reg(2'd0);
    check(rdata_a == 32'hA5, "R2 mask", rdata_a, 32'hA5);
    wr_reg(1, 0, 2'd2, 32'h0);
    rd_reg(2'd0);
    check(rdata_a == 32'hA5, "R2 mask kept", rdata_a, 32'hA5);
    // R10 control
    wr_reg(1, 0, 2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2);
    check(rdata_a == 32'h3, "R10 ctrl", rdata_a, 3);
    check(tick_a == 1'b1, "R10 tick", tick_a, 1);
    wr_reg(1, 0, 2'd2, 32'h1);
    rd_reg(2'd2);
    check(rdata_a == 32'h1, "R10 ctrl ie", rdata_a, 1);
    check(tick_a == 1'b0, "R10 tick off", tick_a, 0);

    // R9 R8 sweep: every pending pattern against many masks
    for (int p = 0; p < 256; p++) begin
      wr_reg(1, 0, 2'd1, 32'hFF);
      pulse(p[N-1:0]);
      rd_reg(2'd1);
      check(rdata_a == p, "R3 R4 latch", rdata_a, p);
      for (int m = 0; m < 256; m += 5) begin
        int e;
        logic [N-1:0] act;
        wr_reg(1, 0, 2'd0, m);
        act = p[N-1:0] & m[N-1:0];
        e = lowest(act);
        check(vld_a == (e >= 0), "R9 vld", vld_a, (e >= 0));
        if (e >= 0) check(idx_a == e, "R9 idx", idx_a, e);
        check(irq_a == (act != 0), "R8 irq", irq_a, (act != 0));
      end
    end
    // R8 gate: ie off
    wr_reg(1, 0, 2'd0, 32'hFF);
    pulse(8'h10);
    wr_reg(1, 0, 2'd2, 32'h0);
    check(irq_a == 1'b0, "R8 ie off", irq_a, 0);
    check(vld_a == 1'b1, "R9 with ie off", vld_a, 1);
    wr_reg(1, 0, 2'd1, 32'hFF);

    // R3 held edge does not re-arm
    @(negedge clk); req = 8'h01;
    @(negedge clk);
    rd_reg(2'd1);
    check(rdata_a == 32'h01, "R3 edge set", rdata_a, 1);
    wr_reg(1, 0, 2'd1, 32'h01);
    @(negedge clk);
    rd_reg(2'd1);
    check(rdata_a == 32'h00, "R3 no rearm", rdata_a, 0);
    @(negedge clk); req = 8'h00;
    @(negedge clk);

    // R4 level cleared while high sets again
    @(negedge clk); req = 8'h10;
    @(negedge clk);
    wr_reg(1, 0, 2'd1, 32'h10);
    rd_reg(2'd1);
    check(rdata_a == 32'h10, "R4 level re-set", rdata_a, 32'h10);
    @(negedge clk); req = 8'h00;
    @(negedge clk);
    wr_reg(1, 0, 2'd1, 32'h10);
    rd_reg(2'd1);
    check(rdata_a == 32'h00, "R4 clear after drop", rdata_a, 0);

    // R7 set beats clear in the same cycle on an edge line
    @(negedge clk);
    req = 8'h02; wr_a = 1'b1; addr = 2'd1; wdata = 32'h02;
    @(negedge clk);
    wr_a = 1'b0; req = 8'h00;
    rd_reg(2'd1);
    check(rdata_a == 32'h02, "R7 set wins", rdata_a, 2);

    // R5 standard polarity: 1 clears, 0 ignored
    wr_reg(1, 1, 2'd1, 32'hFF);
    wr_reg(0, 1, 2'd1, 32'h00);
    pulse(8'hFF);
    wr_reg(1, 0, 2'd1, 32'h00);
    rd_reg(2'd1);
    check(rdata_a == 32'hFF, "R5 zero ignored", rdata_a, 32'hFF);
    wr_reg(1, 0, 2'd1, 32'h04);
    rd_reg(2'd1);
    check(rdata_a == 32'hFB, "R5 one clears", rdata_a, 32'hFB);

    // R6 alternate polarity: 0 clears, 1 ignored
    rd_reg(2'd1);
    check(rdata_b == 32'hFF, "R6 alt latched", rdata_b, 32'hFF);
    wr_reg(0, 1, 2'd1, 32'hFFFF_FFFB);
    rd_reg(2'd1);
    check(rdata_b == 32'hFB, "R6 zero clears", rdata_b, 32'hFB);
    wr_reg(0, 1, 2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1);
    check(rdata_b == 32'hFB, "R6 one ignored", rdata_b, 32'hFB);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule